// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit counter that advances on one of two clock-enable inputs. It is configured through an 8-bit control field, and every write must carry a key. At a selected power-of-two interval the counter expires. In watchdog mode, expiry raises a one-cycle system reset request. In interval-timer mode, expiry only sets a sticky interrupt flag. In both modes the flag sets, and it stays set until `flag_clr` is pulsed. The counter keeps running after expiry, so expiries repeat at the chosen period.

Software must prove intent on every write by placing a fixed key in the upper byte. A write without the key is discarded and is itself treated as a fault: it raises a reset request. The block also conditions an external reset/NMI pin. The pin acts either as a plain active-low reset request or as an NMI source. In NMI mode, the active edge is chosen by a control bit, and flipping that bit on a steady pin level can itself produce an event.

The asynchronous active-low `rst_n` is released through a two-stage synchronizer. The block's registers therefore leave reset on the third rising clock edge after `rst_n` rises.

Top module: `wdog_timer`

## Requirements
- R1: A write with `bus_wdata[15:8]` = 0x5A loads the control byte from `bus_wdata[7:0]`. `bus_rdata` always shows 0x69 in bits 15:8 and the stored control byte in bits 7:0. The control byte is laid out as: bit7 hold, bit6 NMI falling edge, bit5 NMI pin mode, bit4 interval mode, bit3 clear, bit2 slow source, bits1:0 interval select.
- R2: A write with any other upper byte leaves the control byte unchanged. `sys_rst_req` is then high for the cycle after the write edge.
- R3: While bit7 is 1 the counter does not advance and no expiry occurs.
- R4: A keyed write with bit3 = 1 sets the counter to zero at that edge, taking priority over counting and suppressing expiry. Bit3 always reads back as 0.
- R5: Bit2 = 0 counts edges with `fast_tick` high. Bit2 = 1 counts edges with `slow_tick` high.
- R6: Counting up from zero, the first expiry happens on count 32768, 8192, 512 or 64 for interval select 00, 01, 10 or 11, and expiries repeat at that period.
- R7: On expiry `expire_flag` rises in the following cycle in either mode. It stays high until `flag_clr` is sampled high, and a coincident expiry wins over the clear.
- R8: In watchdog mode (bit4 = 0) expiry makes `sys_rst_req` high for exactly the cycle in which the flag rises. In interval mode (bit4 = 1) expiry causes no reset request.
- R9: With bit5 = 0, `pin_rst_req` equals the inverse of `ext_pin`. With bit5 = 1 it is 0.
- R10: With bit5 = 1, `nmi_evt` pulses for one cycle after an edge of `ext_pin XOR bit6` going from 0 to 1. So bit6 = 0 selects rising pin edges and bit6 = 1 selects falling ones. A change of bit6 on a steady pin also counts. With bit5 = 0, `nmi_evt` stays low.
- R11: After reset the control byte is 0x00, so `bus_rdata` = 0x6900, and `expire_flag`, `sys_rst_req` and `nmi_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Control write strobe |
| bus_wdata | input | 16 | Write data: key byte and control byte |
| bus_rdata | output | 16 | Read data: read key and control byte |
| fast_tick | input | 1 | Fast count enable |
| slow_tick | input | 1 | Slow count enable |
| flag_clr | input | 1 | Clears the expiry flag |
| ext_pin | input | 1 | External reset/NMI pin, synchronous |
| expire_flag | output | 1 | Sticky expiry flag |
| sys_rst_req | output | 1 | One-cycle system reset request |
| pin_rst_req | output | 1 | Pin-driven reset request (level) |
| nmi_evt | output | 1 | One-cycle NMI event |

## Verification
The interval taps are each run from a cleared counter with a constant fast enable. This tells apart the four tap positions and shows whether expiry fires on the tap's falling transition rather than on an adjacent bit. A sparse slow enable, paired with a constant fast enable, separates correct source selection from counting on the wrong input. Held, cleared and bad-key writes show whether configuration updates and counting interact in the right order. Pin rising edges, falling edges and edge-select flips on a steady level separate polarity handling from plain level detection.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned BUS_W  = 16;
  localparam int unsigned CTRL_W = 8;
  localparam logic [7:0]  WR_KEY = 8'h5A;
  localparam logic [7:0]  RD_KEY = 8'h69;

  // Field order is software-visible; keep positions fixed.
  typedef struct packed {
    logic       hold;
    logic       nmi_fall;
    logic       nmi_mode;
    logic       intv_mode;
    logic       clr;
    logic       slow_src;
    logic [1:0] intv_sel;
  } ctrl_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic             clr_o,
  output logic             bad_key_o,
  output logic [BUS_W-1:0] rdata_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  key_ok;

  assign key_ok    = (wdata_i[BUS_W-1:CTRL_W] == WR_KEY);
  assign bad_key_o = wr_i & ~key_ok;
  assign clr_o     = wr_i & key_ok & wdata_i[3];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i && key_ok) begin
      ctrl_d     = ctrl_t'(wdata_i[CTRL_W-1:0]);
      ctrl_d.clr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {RD_KEY, ctrl_q};

  // R2
  bad_key_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_o |=> $stable(ctrl_q));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NTAPS = 4,
  parameter int unsigned TAP_IDX [NTAPS] = '{14, 12, 8, 5}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_tick_i,
  input  logic                     slow_tick_i,
  input  logic                     slow_src_i,
  input  logic                     hold_i,
  input  logic [$clog2(NTAPS)-1:0] sel_i,
  input  logic                     clr_i,
  input  logic                     flag_clr_i,
  output logic                     expire_o,
  output logic                     flag_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [NTAPS-1:0] tap_now, tap_next;
  logic             tick, inc_en, expire;
  logic             flag_q, flag_d;

  assign cnt_inc = cnt_q + 1'b1;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    if (TAP_IDX[i] >= CNT_W) begin : g_bad
      initial $error("tap index beyond counter width");
    end
    assign tap_now[i]  = cnt_q[TAP_IDX[i]];
    assign tap_next[i] = cnt_inc[TAP_IDX[i]];
  end

  always_comb begin
    tick   = slow_src_i ? slow_tick_i : fast_tick_i;
    inc_en = tick & ~hold_i;
    expire = inc_en & ~clr_i & tap_now[sel_i] & ~tap_next[sel_i];
    if (clr_i)       cnt_d = '0;
    else if (inc_en) cnt_d = cnt_inc;
    else             cnt_d = cnt_q;
    flag_d = expire | (flag_q & ~flag_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign expire_o = expire;
  assign flag_o   = flag_q;

  // R3
  hold_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i) |=> $stable(cnt_q));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q);

endmodule

// File: rtl/wdog_pin.sv
module wdog_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic nmi_mode_i,
  input  logic nmi_fall_i,
  output logic pin_rst_o,
  output logic nmi_evt_o
);

  logic lvl, lvl_q, evt_q, evt_d;

  // Polarity folded into the level so a polarity flip looks like an edge.
  assign lvl = pin_i ^ nmi_fall_i;

  always_comb begin
    evt_d = nmi_mode_i & lvl & ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      evt_q <= evt_d;
    end
  end

  assign pin_rst_o = ~nmi_mode_i & ~pin_i;
  assign nmi_evt_o = evt_q;

  // R10
  nmi_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(nmi_mode_i));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             flag_clr,
  input  logic             ext_pin,
  output logic             expire_flag,
  output logic             sys_rst_req,
  output logic             pin_rst_req,
  output logic             nmi_evt
);

  logic  rst_int_n;
  ctrl_t ctrl;
  logic  clr_w, bad_key_w, expire_w;
  logic  rreq_q, rreq_d;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_int_n)
  );

  wdog_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_i      (bus_wr),
    .wdata_i   (bus_wdata),
    .ctrl_o    (ctrl),
    .clr_o     (clr_w),
    .bad_key_o (bad_key_w),
    .rdata_o   (bus_rdata)
  );

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fast_tick_i (fast_tick),
    .slow_tick_i (slow_tick),
    .slow_src_i  (ctrl.slow_src),
    .hold_i      (ctrl.hold),
    .sel_i       (ctrl.intv_sel),
    .clr_i       (clr_w),
    .flag_clr_i  (flag_clr),
    .expire_o    (expire_w),
    .flag_o      (expire_flag)
  );

  wdog_pin u_pin (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_i      (ext_pin),
    .nmi_mode_i (ctrl.nmi_mode),
    .nmi_fall_i (ctrl.nmi_fall),
    .pin_rst_o  (pin_rst_req),
    .nmi_evt_o  (nmi_evt)
  );

  always_comb begin
    rreq_d = bad_key_w | (expire_w & ~ctrl.intv_mode);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rreq_q <= 1'b0;
    else            rreq_q <= rreq_d;
  end

  assign sys_rst_req = rreq_q;

  // R8
  intv_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (expire_w && ctrl.intv_mode && !bad_key_w) |=> !sys_rst_req);

  // R8
  wd_reset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (expire_w && !ctrl.intv_mode) |=> (sys_rst_req && expire_flag));

endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        fast_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic        flag_clr = 1'b0;
  logic        ext_pin = 1'b1;
  logic        expire_flag, sys_rst_req, pin_rst_req, nmi_evt;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit slow_en = 0;
  int slow_ph = 0;

  always #5 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .flag_clr(flag_clr), .ext_pin(ext_pin), .expire_flag(expire_flag),
    .sys_rst_req(sys_rst_req), .pin_rst_req(pin_rst_req), .nmi_evt(nmi_evt)
  );

  // Behavioural reference model
  logic [7:0] m_ctrl;
  int         m_cnt, m_rstcnt;
  bit         m_flag, m_rst, m_nmi, m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h00; m_cnt = 0; m_flag = 0; m_rst = 0; m_nmi = 0;
      m_lvl = 0; m_rstcnt = 0;
    end else if (m_rstcnt < 2) begin
      m_rstcnt++;
    end else begin
      bit tick, inc, wr_ok, bad_wr, clr, exp_now, lvl;
      int period;
      tick    = m_ctrl[2] ? slow_tick : fast_tick;
      inc     = tick && !m_ctrl[7];
      wr_ok   = bus_wr && (bus_wdata[15:8] == 8'h5A);
      bad_wr  = bus_wr && !wr_ok;
      clr     = wr_ok && bus_wdata[3];
      case (m_ctrl[1:0])
        2'b00: period = 32768;
        2'b01: period = 8192;
        2'b10: period = 512;
        default: period = 64;
      endcase
      exp_now = inc && !clr && (((m_cnt + 1) % period) == 0);
      if (clr)      m_cnt = 0;
      else if (inc) m_cnt = (m_cnt + 1) % 65536;
      m_rst  = bad_wr || (exp_now && !m_ctrl[4]);
      m_flag = exp_now || (m_flag && !flag_clr);
      lvl    = ext_pin ^ m_ctrl[6];
      m_nmi  = m_ctrl[5] && lvl && !m_lvl;
      m_lvl  = lvl;
      if (wr_ok) m_ctrl = bus_wdata[7:0] & 8'hF7;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_rstcnt >= 2 && !done) begin
      chk("R1 rdata", bus_rdata, {8'h69, m_ctrl});
      chk("R7 flag", expire_flag, m_flag);
      chk("R8 sys_rst_req", sys_rst_req, m_rst);
      chk("R9 pin_rst_req", pin_rst_req, !m_ctrl[5] && !ext_pin);
      chk("R10 nmi_evt", nmi_evt, m_nmi);
    end
  end

  always @(posedge clk) begin
    #1;
    if (slow_en) begin
      slow_ph = (slow_ph + 1) % 4;
      slow_tick = (slow_ph == 0);
    end else begin
      slow_tick = 0;
    end
  end

  task automatic wr(input logic [15:0] d);
    @(posedge clk); #1; bus_wr = 1; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 0; bus_wdata = 16'h0;
  endtask

  task automatic clr_flag();
    @(posedge clk); #1; flag_clr = 1;
    @(posedge clk); #1; flag_clr = 0;
  endtask

  task automatic wait_flag(output int n, input int lim);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!expire_flag && n < lim);
  endtask

  task automatic wait_rst(output int n, input int lim);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!sys_rst_req && n < lim);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog timeout act=hang exp=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 rdata", bus_rdata, 16'h6900);
    chk("R11 flag", expire_flag, 0);
    chk("R11 sys_rst_req", sys_rst_req, 0);
    chk("R11 nmi_evt", nmi_evt, 0);

    // R6 /64 interval mode, clear on write
    fast_tick = 1;
    wr(16'h5A1B);
    chk("R4 clear bit reads 0", bus_rdata, 16'h691B & 16'hFFF7);
    wait_flag(n, 200);
    chk("R6 /64 period", n, 64);
    chk("R8 no reset in interval mode", sys_rst_req, 0);
    repeat (10) @(posedge clk);
    #1 chk("R7 flag sticky", expire_flag, 1);

    // R3 hold
    wr(16'h5A9B);
    clr_flag();
    #1 chk("R7 flag cleared", expire_flag, 0);
    repeat (300) @(posedge clk);
    #1 chk("R3 held no expiry", expire_flag, 0);
    wr(16'h5A13);
    wait_flag(n, 200);
    chk("R3 resumes from held zero", n, 64);
    wait_flag(n, 10);
    chk("R7 flag stays without clear", n, 1);
    clr_flag();
    wait_flag(n, 200);
    chk("R6 periodic /64", n < 64 && expire_flag, 1);

    // R5 slow source, /512
    wr(16'h5A9E);
    clr_flag();
    slow_en = 1;
    wr(16'h5A16);
    repeat (1000) @(posedge clk);
    #1 chk("R5 fast enable ignored", expire_flag, 0);
    wait_flag(n, 3000);
    chk("R5 slow expiry reached", expire_flag, 1);
    slow_en = 0;

    // R8 watchdog mode /8192
    wr(16'h5A89);
    clr_flag();
    wr(16'h5A01);
    wait_rst(n, 9000);
    chk("R8 watchdog reset at /8192", n, 8192);
    chk("R8 flag with reset", expire_flag, 1);
    @(posedge clk); #1;
    chk("R8 reset one cycle", sys_rst_req, 0);

    // R6 /32768
    wr(16'h5A98);
    clr_flag();
    wr(16'h5A10);
    wait_flag(n, 33000);
    chk("R6 /32768 period", n, 32768);

    // R2 bad key
    wr(16'h5A90);
    wr(16'h1234);
    chk("R2 reset request on bad key", sys_rst_req, 1);
    chk("R2 control unchanged", bus_rdata, 16'h6990);
    @(posedge clk); #1;
    chk("R2 request one cycle", sys_rst_req, 0);

    // R9 pin reset mode (held, pin mode 0)
    ext_pin = 0; #1;
    chk("R9 pin low requests reset", pin_rst_req, 1);
    @(posedge clk); #1 ext_pin = 1; #1;
    chk("R9 pin high no reset", pin_rst_req, 0);
    @(posedge clk); #1 ext_pin = 0;
    repeat (3) @(posedge clk);
    #1 chk("R10 no nmi in reset mode", nmi_evt, 0);
    ext_pin = 1;

    // R10 NMI, rising then falling selection
    wr(16'h5AA0);
    chk("R9 nmi mode masks pin reset", pin_rst_req, 0);
    @(posedge clk); #1 ext_pin = 0;
    repeat (3) @(posedge clk);
    #1 ext_pin = 1;
    @(posedge clk); #1;
    chk("R10 rising edge event", nmi_evt, 1);
    @(posedge clk); #1;
    chk("R10 event one cycle", nmi_evt, 0);
    ext_pin = 0;
    repeat (2) @(posedge clk);
    #1 chk("R10 falling ignored in rising mode", nmi_evt, 0);
    wr(16'h5AE0);
    @(posedge clk); #1;
    chk("R10 edge-select flip on steady pin", nmi_evt, 1);
    ext_pin = 1;
    repeat (2) @(posedge clk);
    #1 chk("R10 rising ignored in falling mode", nmi_evt, 0);
    ext_pin = 0;
    @(posedge clk); #1;
    chk("R10 falling edge event", nmi_evt, 1);
    repeat (4) @(posedge clk);
    #1;
    finish_run();
  end

endmodule